// File: doc/BRIEF.md
# Token LAN Controller Register Front-End

This block holds the registers a processor sees when it drives a token-passing network controller. One address reads back an eight-bit status word and, when written, loads an interrupt mask. A second address accepts eight-bit commands. Each command carries a three-bit opcode in its low bits, and its upper bits hold fields such as a buffer page, a broadcast enable, a long-packet enable or flag-clear selects. The block turns these commands into control state for a protocol engine: which page to transmit from, which page to receive into, whether broadcasts are taken, and whether long packets are allowed.

A protocol engine, modelled here only as event pulses, reports when a transmission completes, when it is acknowledged, when a packet lands, and when the ring reconfigures. Each event sets a sticky status flag. The block raises an interrupt while any of the three interruptible flags is set and unmasked. Token handling, cabling, reconfiguration timing and the packet buffer memory sit outside this block.

Top module: `tokenLanRegs`

## Requirements
- R1: After reset the status word reads transmitter-available (bit 0) = 1, transmit-acknowledged (bit 1) = 0, reconfigured (bit 2) = 0, power-on (bit 4) = 1, receive-inhibited (bit 7) = 1. The mask is all zero and irq is 0. Pages, the broadcast enable, the long-packet enable and the filled page are all 0.
- R2: Status bit 3 follows testIn, bit 5 follows etIn[0] and bit 6 follows etIn[1], with no clock delay.
- R3: A write with regSel=0 loads the mask, keeping only bits 0, 2 and 7. irq is the OR of (bit0 & mask0), (bit2 & mask2) and (bit7 & mask7), computed from registered state, so it changes in the cycle after the flag or the mask changes.
- R4: With regSel=1, command 000nn011 (opcode 3, bits 7:5 zero) sets txPage=nn and clears bits 0 and 1, so txBusy goes high.
- R5: Command 00000001 sets bit 0, which drops txBusy. Command 00000000 is reserved and has no effect.
- R6: Command b00nn100 (opcode 4, bits 6:5 zero) sets rxPage=nn and bcastEn=b, and clears bit 7, so rxArmed goes high.
- R7: Command 0000c101 (opcode 5, bits 7:4 zero) sets longPktEn=c.
- R8: Command 000rp110 (opcode 6, bits 7:5 zero) clears bit 4 when p (bit 3) is 1 and clears bit 2 when r (bit 4) is 1. Setting both clears both.
- R9: evTxDone sets bit 0, evTxAck sets bit 1, evRxDone sets bit 7 and evRecon sets bit 2. An event setting a bit wins over a command clearing that bit in the same cycle.
- R10: evRxDone copies the rxPage held before that edge into filledPage.
- R11: A command with a nonzero bit in a position that must be zero, or with opcode 0, 2 or 7, changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 = status/mask address, 1 = command address |
| wrData | input | 8 | Write data |
| evTxDone | input | 1 | Transmission finished |
| evTxAck | input | 1 | Transmission acknowledged |
| evRxDone | input | 1 | Packet received |
| evRecon | input | 1 | Ring reconfigured |
| etIn | input | 2 | Timing jumper inputs |
| testIn | input | 1 | Test status input |
| statusOut | output | 8 | Status word |
| irq | output | 1 | Interrupt request |
| txBusy | output | 1 | Transmit in progress (bit 0 clear) |
| txPage | output | 2 | Transmit buffer page |
| rxArmed | output | 1 | Receiver enabled (bit 7 clear) |
| rxPage | output | 2 | Receive buffer page |
| bcastEn | output | 1 | Broadcast reception enabled |
| longPktEn | output | 1 | Long packets enabled |
| filledPage | output | 2 | Page of the last received packet |

## Verification
Every flag, the mask and every configuration field reaches a port: the flags through statusOut, the mask through irq, the rest through their own outputs. A wrong internal value therefore shows one clock edge after the write or event that produced it. The bench compares all outputs after every cycle, so a decode fault shows at once. So does a wrong set/clear priority or a stale page capture. Faults in the mask show only when a matching flag is set, and the random phase keeps flags and masks overlapping often.

// File: rtl/tokenLanPkg.sv
package tokenLanPkg;
  localparam int DATA_W  = 8;
  localparam int PAGE_W  = 2;
  localparam int OPC_W   = 3;
  localparam int PAGE_LO = OPC_W;

  // status bit positions
  localparam int ST_TA    = 0;
  localparam int ST_TMA   = 1;
  localparam int ST_RECON = 2;
  localparam int ST_TEST  = 3;
  localparam int ST_POR   = 4;
  localparam int ST_ET1   = 5;
  localparam int ST_ET2   = 6;
  localparam int ST_RI    = 7;

  localparam logic [DATA_W-1:0] MASK_IMPL =
    DATA_W'((1 << ST_TA) | (1 << ST_RECON) | (1 << ST_RI));

  typedef enum logic [OPC_W-1:0] {
    OP_RSVD  = 3'd0,
    OP_TXOFF = 3'd1,
    OP_UNUSED2 = 3'd2,
    OP_TXON  = 3'd3,
    OP_RXON  = 3'd4,
    OP_CFG   = 3'd5,
    OP_CLR   = 3'd6,
    OP_UNUSED7 = 3'd7
  } opcode_e;

  typedef struct packed {
    logic loadMask;
    logic txOn;
    logic txOff;
    logic rxOn;
    logic cfg;
    logic clrPor;
    logic clrRecon;
  } strobes_t;
endpackage

// File: rtl/tokenLanDecode.sv
module tokenLanDecode
  import tokenLanPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              regSel,
  input  logic [DATA_W-1:0] wrData,
  output strobes_t          stb
);
  opcode_e opc;
  assign opc = opcode_e'(wrData[OPC_W-1:0]);

  always_comb begin
    stb = '0;
    if (wrEn) begin
      if (!regSel) begin
        stb.loadMask = 1'b1;
      end else begin
        unique case (opc)
          OP_TXOFF: stb.txOff = (wrData[DATA_W-1:OPC_W] == '0);
          OP_TXON:  stb.txOn  = (wrData[DATA_W-1:PAGE_LO+PAGE_W] == '0);
          OP_RXON:  stb.rxOn  = (wrData[DATA_W-2:PAGE_LO+PAGE_W] == '0);
          OP_CFG:   stb.cfg   = (wrData[DATA_W-1:OPC_W+1] == '0);
          OP_CLR: begin
            if (wrData[DATA_W-1:OPC_W+2] == '0) begin
              stb.clrPor   = wrData[OPC_W];
              stb.clrRecon = wrData[OPC_W+1];
            end
          end
          default: stb = '0;
        endcase
      end
    end
  end

  // R11: at most one command action per write
  p_single_action_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.loadMask, stb.txOn, stb.txOff, stb.rxOn, stb.cfg, stb.clrPor | stb.clrRecon}));

  // R11: nothing decodes without a write strobe
  p_no_strobe_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> (stb == '0));
endmodule

// File: rtl/tokenLanFlags.sv
module tokenLanFlags
  import tokenLanPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              evTxDone,
  input  logic              evTxAck,
  input  logic              evRxDone,
  input  logic              evRecon,
  input  logic [1:0]        etIn,
  input  logic              testIn,
  output logic [DATA_W-1:0] statusOut,
  output logic              irq,
  output logic              txBusy,
  output logic [PAGE_W-1:0] txPage,
  output logic              rxArmed,
  output logic [PAGE_W-1:0] rxPage,
  output logic              bcastEn,
  output logic              longPktEn,
  output logic [PAGE_W-1:0] filledPage
);
  logic ta, tma, recon, por, ri;
  logic [DATA_W-1:0] mask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ta         <= 1'b1;
      tma        <= 1'b0;
      recon      <= 1'b0;
      por        <= 1'b1;
      ri         <= 1'b1;
      mask       <= '0;
      txPage     <= '0;
      rxPage     <= '0;
      bcastEn    <= 1'b0;
      longPktEn  <= 1'b0;
      filledPage <= '0;
    end else begin
      if (stb.loadMask) mask <= wrData & MASK_IMPL;

      if (evTxDone || stb.txOff) ta <= 1'b1;
      else if (stb.txOn)         ta <= 1'b0;

      if (evTxAck)          tma <= 1'b1;
      else if (stb.txOn)    tma <= 1'b0;

      if (evRxDone)         ri <= 1'b1;
      else if (stb.rxOn)    ri <= 1'b0;

      if (evRecon)           recon <= 1'b1;
      else if (stb.clrRecon) recon <= 1'b0;

      if (stb.clrPor) por <= 1'b0;

      if (stb.txOn) txPage <= wrData[PAGE_LO +: PAGE_W];
      if (stb.rxOn) begin
        rxPage  <= wrData[PAGE_LO +: PAGE_W];
        bcastEn <= wrData[DATA_W-1];
      end
      if (stb.cfg) longPktEn <= wrData[OPC_W];
      if (evRxDone) filledPage <= rxPage;
    end
  end

  always_comb begin
    statusOut           = '0;
    statusOut[ST_TA]    = ta;
    statusOut[ST_TMA]   = tma;
    statusOut[ST_RECON] = recon;
    statusOut[ST_TEST]  = testIn;
    statusOut[ST_POR]   = por;
    statusOut[ST_ET1]   = etIn[0];
    statusOut[ST_ET2]   = etIn[1];
    statusOut[ST_RI]    = ri;
  end

  assign irq     = |(statusOut & mask);
  assign txBusy  = ~ta;
  assign rxArmed = ~ri;

  p_txon_loads_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.txOn && !evTxDone && !evTxAck) |=> (txBusy && !tma && txPage == $past(wrData[PAGE_LO +: PAGE_W])));

  p_por_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrPor |=> !por);

  p_recon_event_r9: assert property (@(posedge clk) disable iff (!rstN)
    evRecon |=> recon);

  p_rx_capture_r10: assert property (@(posedge clk) disable iff (!rstN)
    evRxDone |=> (!rxArmed && filledPage == $past(rxPage)));

  p_irq_needs_mask_r3: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (mask != '0));
endmodule

// File: rtl/tokenLanRegs.sv
module tokenLanRegs
  import tokenLanPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              regSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              evTxDone,
  input  logic              evTxAck,
  input  logic              evRxDone,
  input  logic              evRecon,
  input  logic [1:0]        etIn,
  input  logic              testIn,
  output logic [DATA_W-1:0] statusOut,
  output logic              irq,
  output logic              txBusy,
  output logic [PAGE_W-1:0] txPage,
  output logic              rxArmed,
  output logic [PAGE_W-1:0] rxPage,
  output logic              bcastEn,
  output logic              longPktEn,
  output logic [PAGE_W-1:0] filledPage
);
  strobes_t stb;

  tokenLanDecode u_decode (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regSel(regSel),
    .wrData(wrData), .stb(stb)
  );

  tokenLanFlags u_flags (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .evTxDone(evTxDone), .evTxAck(evTxAck), .evRxDone(evRxDone),
    .evRecon(evRecon), .etIn(etIn), .testIn(testIn),
    .statusOut(statusOut), .irq(irq), .txBusy(txBusy), .txPage(txPage),
    .rxArmed(rxArmed), .rxPage(rxPage), .bcastEn(bcastEn),
    .longPktEn(longPktEn), .filledPage(filledPage)
  );
endmodule

// File: tb/tokenLanRegs_bench.sv
module tokenLanRegs_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, regSel = 1'b0;
  logic [7:0] wrData = '0;
  logic evTxDone = 0, evTxAck = 0, evRxDone = 0, evRecon = 0;
  logic [1:0] etIn = '0;
  logic testIn = 1'b0;
  logic [7:0] statusOut;
  logic irq, txBusy, rxArmed, bcastEn, longPktEn;
  logic [1:0] txPage, rxPage, filledPage;

  int errors = 0;
  int checks = 0;

  // model state
  bit mTa, mTma, mRecon, mPor, mRi, mBc, mLp;
  bit [7:0] mMask;
  bit [1:0] mTxPg, mRxPg, mFill;

  always #(CLK_PERIOD/2) clk = ~clk;

  tokenLanRegs u_tokenLanRegs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regSel(regSel), .wrData(wrData),
    .evTxDone(evTxDone), .evTxAck(evTxAck), .evRxDone(evRxDone),
    .evRecon(evRecon), .etIn(etIn), .testIn(testIn),
    .statusOut(statusOut), .irq(irq), .txBusy(txBusy), .txPage(txPage),
    .rxArmed(rxArmed), .rxPage(rxPage), .bcastEn(bcastEn),
    .longPktEn(longPktEn), .filledPage(filledPage)
  );

  function automatic bit [7:0] expStatus();
    return {mRi, etIn[1], etIn[0], mPor, testIn, mRecon, mTma, mTa};
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    bit [7:0] s;
    s = expStatus();
    check({tag, " status"}, statusOut, s);
    check({tag, " irq R3"}, irq, |(s & mMask));
    check({tag, " txBusy"}, txBusy, !mTa);
    check({tag, " rxArmed"}, rxArmed, !mRi);
    check({tag, " txPage"}, txPage, mTxPg);
    check({tag, " rxPage"}, rxPage, mRxPg);
    check({tag, " bcastEn"}, bcastEn, mBc);
    check({tag, " longPktEn"}, longPktEn, mLp);
    check({tag, " filledPage R10"}, filledPage, mFill);
  endtask

  function automatic void modelReset();
    mTa = 1; mTma = 0; mRecon = 0; mPor = 1; mRi = 1;
    mMask = 0; mTxPg = 0; mRxPg = 0; mBc = 0; mLp = 0; mFill = 0;
  endfunction

  // model step from the requirements
  function automatic void modelStep(bit w, bit sel, bit [7:0] d,
                                    bit eTd, bit eTa, bit eRd, bit eRc);
    bit txOn = 0, txOff = 0, rxOn = 0, cfg = 0, cP = 0, cR = 0;
    bit [1:0] oldRx = mRxPg;
    if (w && !sel) mMask = d & 8'h85;
    if (w && sel) begin
      case (d[2:0])
        3'd1: txOff = (d[7:3] == 0);
        3'd3: txOn  = (d[7:5] == 0);
        3'd4: rxOn  = (d[6:5] == 0);
        3'd5: cfg   = (d[7:4] == 0);
        3'd6: if (d[7:5] == 0) begin cP = d[3]; cR = d[4]; end
        default: ;
      endcase
    end
    if (eTd || txOff) mTa = 1; else if (txOn) mTa = 0;
    if (eTa) mTma = 1; else if (txOn) mTma = 0;
    if (eRd) mRi = 1; else if (rxOn) mRi = 0;
    if (eRc) mRecon = 1; else if (cR) mRecon = 0;
    if (cP) mPor = 0;
    if (txOn) mTxPg = d[4:3];
    if (rxOn) begin mRxPg = d[4:3]; mBc = d[7]; end
    if (cfg) mLp = d[3];
    if (eRd) mFill = oldRx;
  endfunction

  task automatic step(bit w, bit sel, bit [7:0] d, bit eTd, bit eTa,
                      bit eRd, bit eRc, string tag);
    wrEn = w; regSel = sel; wrData = d;
    evTxDone = eTd; evTxAck = eTa; evRxDone = eRd; evRecon = eRc;
    modelStep(w, sel, d, eTd, eTa, eRd, eRc);
    @(negedge clk);
    wrEn = 0; evTxDone = 0; evTxAck = 0; evRxDone = 0; evRecon = 0;
    checkAll(tag);
  endtask

  task automatic cmd(bit [7:0] d, string tag);
    step(1, 1, d, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1 reset");

    // R2 live inputs
    etIn = 2'b10; testIn = 1; #1;
    check("R2 status live", statusOut, expStatus());
    etIn = 2'b01; testIn = 0; #1;
    check("R2 status live", statusOut, expStatus());

    // R3 mask load: only bits 0,2,7; TA and RI set at reset
    step(1, 0, 8'hFF, 0, 0, 0, 0, "R3 mask all");
    check("R3 irq set", irq, 1);
    step(1, 0, 8'h7A, 0, 0, 0, 0, "R3 mask unimpl");
    check("R3 irq unimpl bits", irq, 0);
    step(1, 0, 8'h01, 0, 0, 0, 0, "R3 mask TA");

    // R4 tx start page 2
    cmd(8'b000_10_011, "R4 txon");
    check("R4 busy", txBusy, 1);
    check("R3 irq after TA clear", irq, 0);
    step(0, 0, 0, 0, 1, 0, 0, "R9 ack");
    step(0, 0, 0, 1, 0, 0, 0, "R9 txdone");
    check("R9 irq on done", irq, 1);
    cmd(8'b000_01_011, "R4 txon again");
    // R5
    cmd(8'b0000_0001, "R5 txoff");
    check("R5 not busy", txBusy, 0);
    cmd(8'b000_11_011, "R4 txon p3");
    cmd(8'b0000_0000, "R5 reserved ignored");
    check("R5 reserved busy kept", txBusy, 1);
    // R11 bad fields and unused opcodes
    cmd(8'b0000_1001, "R11 txoff bad");
    cmd(8'b001_00_011, "R11 txon bad");
    cmd(8'b001_01_100, "R11 rxon bad");
    cmd(8'b0001_1101, "R11 cfg bad");
    cmd(8'b001_11_110, "R11 clr bad");
    cmd(8'b111_11_010, "R11 op2");
    cmd(8'b111_11_111, "R11 op7");
    // R6
    cmd(8'b1_00_10_100, "R6 rxon bcast");
    check("R6 bcast", bcastEn, 1);
    check("R6 armed", rxArmed, 1);
    step(0, 0, 0, 0, 0, 1, 0, "R10 rxdone");
    check("R10 filled", filledPage, 2);
    // R10 capture old page while re-arming same cycle
    step(1, 1, 8'b0_00_01_100, 0, 0, 1, 0, "R10 rx same cycle");
    check("R9 rx set wins", rxArmed, 0);
    // R7
    cmd(8'b0000_1101, "R7 long on");
    check("R7 long", longPktEn, 1);
    cmd(8'b0000_0101, "R7 long off");
    // R8
    step(0, 0, 0, 0, 0, 0, 1, "R9 recon");
    cmd(8'b000_01_110, "R8 clr por");
    check("R8 por", statusOut[4], 0);
    step(1, 1, 8'b000_10_110, 0, 0, 0, 1, "R9 recon wins clear");
    check("R9 recon kept", statusOut[2], 1);
    cmd(8'b000_11_110, "R8 clr both");
    check("R8 recon", statusOut[2], 0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      bit [7:0] d;
      bit [2:0] op;
      op = 3'($urandom_range(0, 7));
      d = 8'($urandom());
      if ($urandom_range(0, 3) != 0) begin
        case (op)
          3'd1: d = 8'h01;
          3'd3: d = {3'b0, d[4:3], 3'd3};
          3'd4: d = {d[7], 2'b0, d[4:3], 3'd4};
          3'd5: d = {4'b0, d[3], 3'd5};
          3'd6: d = {3'b0, d[4:3], 3'd6};
          default: d = {d[7:3], op};
        endcase
      end
      etIn = 2'($urandom()); testIn = 1'($urandom());
      step(1'($urandom_range(0, 2) != 0), 1'($urandom_range(0, 4) != 0), d,
           1'($urandom_range(0, 5) == 0), 1'($urandom_range(0, 5) == 0),
           1'($urandom_range(0, 5) == 0), 1'($urandom_range(0, 7) == 0),
           "R9 R11 random");
    end

    // reset again
    rstN = 0;
    modelReset();
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
    checkAll("R1 rereset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule